// File: doc/BRIEF.md
# Random Number Register Front-End

This block sits between a raw entropy bit source and a simple register bus. Software programs a sampling divider, sets the enable bit and then asks for data by writing a bit count into the fill-request register. The block samples the raw entropy input once per divided tick. It packs each sampled bit into an eight-word output buffer and lowers the outstanding count by one for each bit stored.

When the outstanding count reads back as zero, the requested bits are in the buffer and software can read the words. The divider field is written already shifted left by one bit. The tick period is twice the stored divide value, so the sampling rate can be held under a target frequency. The post-processing control register is kept for software, and bits always go into the buffer unprocessed.

Top module: `rng_frontend`

## Requirements
- R1: After a synchronous active-low reset, the divider (0x00), control (0x20), post-processing (0x30) and fill-request (0x50) registers read 0. All buffer words (0x80 to 0x9C) read 0, and the generator is disabled.
- R2: A write to the divider register at 0x00 stores write-data bits 15:1 as the divide value. A read returns that value shifted left by one, with bit 0 and bits 31:16 at zero.
- R3: Bit 31 of the control register at 0x20 enables sampling and reads back as written. While it is clear, no bit is captured and the outstanding count does not change.
- R4: A write to the fill-request register at 0x50 loads the outstanding bit count. Reading 0x50 returns the bits still outstanding, and a value of zero means the fill is complete.
- R5: A requested count greater than 256 is loaded as 256.
- R6: With divide value D, where a stored 0 acts as 1, bit n of a request is captured from the raw input at the 2*D*(n+1)-th rising clock edge after the edge that accepted the request write. The outstanding count drops by exactly one at each capture.
- R7: Bit n of a request is stored in buffer word n/32 at address 0x80 + 4*(n/32), in bit position n%32. Word 0 fills first, least significant bit first.
- R8: A request written while a fill is in progress reloads the count. It also restarts the tick phase and the fill position at word 0, bit 0.
- R9: The post-processing register at 0x30 stores and returns all 32 bits. With it at zero, the buffer holds the raw input bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| raw_bit | input | 1 | Raw entropy bit, sampled on tick |

## Verification
Read data is combinational from the address, so a register write is visible half a cycle after the edge that accepts it. The bench sets the address on a falling edge and samples shortly after. The bench numbers the rising edges from the one that accepts a fill request and records the raw input at each of them. It expects bit n from the record at edge 2*D*(n+1). It reads the outstanding count one edge before the final capture and again at the final capture, so the one-edge boundary is pinned on both sides.

// File: rtl/rng_fe_pkg.sv
// Shared constants for the random number register front-end.
// Assumes an 8-bit byte address bus with 32-bit word registers.
package rng_fe_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned WORD_W   = 32;
    localparam logic [7:0]  OFS_DIV  = 8'h00;
    localparam logic [7:0]  OFS_CTRL = 8'h20;
    localparam logic [7:0]  OFS_POST = 8'h30;
    localparam logic [7:0]  OFS_FILL = 8'h50;
    localparam logic [7:0]  OFS_BUF  = 8'h80;
    localparam int unsigned EN_BIT   = 31;
endpackage

// File: rtl/rng_fe_tick.sv
// Sample tick generator: one-cycle pulse every 2*div clocks (div 0 acts as 1).
// Assumes restart is a one-cycle strobe; the phase counter holds at 0 while disabled.
module rng_fe_tick #(
    parameter int unsigned DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W:0] period;
    logic [DIV_W:0] cnt_q;

    // Period in clocks, with a zero divide value mapped to one.
    always_comb period = (div == '0) ? (DIV_W+1)'(2) : {div, 1'b0};

    assign tick = en && (cnt_q == period - 1'b1);

    // Phase counter: cleared by reset, disable or restart, wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!en || restart) cnt_q <= '0;
        else if (tick)           cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rng_fe_fill.sv
// Fill engine: holds the outstanding bit count and the next buffer bit position.
// Assumes load_val never exceeds the buffer size; load wins over a tick.
module rng_fe_fill #(
    parameter int unsigned PTR_W = 8,
    parameter int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] remaining,
    output logic [PTR_W-1:0] ptr,
    output logic             cap_we
);
    assign cap_we = tick && (remaining != '0) && !load;

    // Count down per captured bit and advance the write position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            ptr       <= '0;
        end else if (load) begin
            remaining <= load_val;
            ptr       <= '0;
        end else if (cap_we) begin
            remaining <= remaining - 1'b1;
            ptr       <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rng_fe_buffer.sv
// Output buffer: WORDS words of 32 bits, written one bit at a time at ptr.
// Assumes WORDS is a power of two, at least 2; ptr upper bits select the word.
module rng_fe_buffer #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned PTR_W = $clog2(WORDS * 32)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PTR_W-1:0]       ptr,
    input  logic                   din,
    output logic [WORDS-1:0][31:0] words
);
    localparam int unsigned WIDX_W = PTR_W - 5;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // One storage word: cleared by reset, single-bit update when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (we && (ptr[PTR_W-1:5] == WIDX_W'(w)))
                words[w][ptr[4:0]] <= din;
        end
    end
endmodule

// File: rtl/rng_frontend.sv
// Register front-end for a random bit generator: divider, enable, post-processing
// and fill-request registers plus a word buffer filled from raw_bit.
// Assumes single-cycle writes and combinational reads on the address.
module rng_frontend
    import rng_fe_pkg::*;
#(
    parameter int unsigned WORDS = 8,
    parameter int unsigned DIV_W = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        raw_bit
);
    localparam int unsigned MAX_BITS = WORDS * WORD_W;
    localparam int unsigned PTR_W    = $clog2(MAX_BITS);
    localparam int unsigned CNT_W    = PTR_W + 1;
    localparam int unsigned WIDX_W   = PTR_W - 5;

    logic [DIV_W-1:0]       div_q;
    logic                   en_q;
    logic [31:0]            post_q;
    logic                   fill_wr;
    logic [CNT_W-1:0]       req_bits;
    logic                   tick;
    logic [CNT_W-1:0]       remaining;
    logic [PTR_W-1:0]       ptr;
    logic                   cap_we;
    logic [WORDS-1:0][31:0] words;
    logic [7:0]             buf_off;
    logic                   buf_hit;

    assign fill_wr = bus_we && (bus_addr == OFS_FILL);

    // Clamp the requested bit count to the buffer capacity.
    always_comb begin
        if (bus_wdata > 32'(MAX_BITS)) req_bits = CNT_W'(MAX_BITS);
        else                           req_bits = bus_wdata[CNT_W-1:0];
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            en_q   <= 1'b0;
            post_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_DIV:  div_q  <= bus_wdata[DIV_W:1];
                OFS_CTRL: en_q   <= bus_wdata[EN_BIT];
                OFS_POST: post_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    rng_fe_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .restart(fill_wr),
        .div(div_q), .tick(tick)
    );

    rng_fe_fill #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .load(fill_wr), .load_val(req_bits),
        .tick(tick), .remaining(remaining), .ptr(ptr), .cap_we(cap_we)
    );

    rng_fe_buffer #(.WORDS(WORDS), .PTR_W(PTR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(cap_we), .ptr(ptr),
        .din(raw_bit), .words(words)
    );

    assign buf_off = bus_addr - OFS_BUF;
    assign buf_hit = (bus_addr >= OFS_BUF) && (buf_off < 8'(4 * WORDS))
                     && (buf_off[1:0] == 2'b00);

    // Read multiplexer over registers and buffer words.
    always_comb begin
        bus_rdata = '0;
        if (buf_hit) begin
            bus_rdata = words[buf_off[WIDX_W+1:2]];
        end else begin
            case (bus_addr)
                OFS_DIV:  bus_rdata = 32'({div_q, 1'b0});
                OFS_CTRL: bus_rdata[EN_BIT] = en_q;
                OFS_POST: bus_rdata = post_q;
                OFS_FILL: bus_rdata = 32'(remaining);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rng_frontend_chk.sv
// Property checker for rng_frontend, attached by bind below.
// Assumes reset is held for at least two clock edges.
module rng_frontend_chk #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned MAX_BITS = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_wr,
    input logic [CNT_W-1:0] req_bits,
    input logic             en_q,
    input logic             tick,
    input logic [CNT_W-1:0] remaining
);
    // R4: a request write loads the outstanding count on the next edge.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        fill_wr |=> remaining == $past(req_bits));

    // R4: a finished fill stays finished until a new request.
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0 && !fill_wr) |=> remaining == '0);

    // R5: the outstanding count never exceeds the buffer capacity.
    a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= CNT_W'(MAX_BITS));

    // R3: no progress while disabled.
    a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !fill_wr) |=> $stable(remaining));

    // R3: ticks only occur with the enable set.
    a_r3_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en_q);

    // R6: without a new request the count falls by at most one per edge.
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_wr |=> (remaining == $past(remaining)
                      || remaining == $past(remaining) - 1'b1));
endmodule

bind rng_frontend rng_frontend_chk #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_wr(fill_wr), .req_bits(req_bits),
    .en_q(en_q), .tick(tick), .remaining(remaining)
);

// File: tb/tb_rng_frontend.sv
`timescale 1ns/1ps
module tb_rng_frontend;
    localparam logic [7:0] A_DIV  = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_POST = 8'h30;
    localparam logic [7:0] A_FILL = 8'h50;
    localparam logic [7:0] A_BUF  = 8'h80;
    localparam int NVEC = 5;
    localparam int VEC_DIV [NVEC] = '{1, 2, 0, 3, 1};
    localparam int VEC_REQ [NVEC] = '{32, 64, 16, 8, 300};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        raw_bit = 1'b0;

    logic [15:0] lfsr = 16'hACE1;
    logic        hist [0:2047];
    int          kk = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    rng_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_bit(raw_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step_raw();
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        raw_bit = lfsr[0];
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic start_fill(input int req);
        bus_addr = A_FILL; bus_wdata = 32'(req); bus_we = 1'b1;
        @(posedge clk);
        hist[0] = raw_bit;
        @(negedge clk);
        bus_we = 1'b0;
        step_raw();
        kk = 1;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            hist[kk] = raw_bit;
            kk++;
            @(negedge clk);
            step_raw();
        end
    endtask

    function automatic int exp_rem(input int nreq, input int d);
        int got = (kk - 1) / (2 * d);
        return (got >= nreq) ? 0 : nreq - got;
    endfunction

    // R7: compare buffer words against recorded raw bits for nbits captures.
    task automatic check_words(input int nbits, input int d, input string tag);
        logic [31:0] act, exp, mask;
        for (int w = 0; w < (nbits + 31) / 32; w++) begin
            exp = '0; mask = '0;
            for (int b = 0; b < 32; b++) begin
                if (32 * w + b < nbits) begin
                    mask[b] = 1'b1;
                    exp[b]  = hist[2 * d * (32 * w + b + 1)];
                end
            end
            rd(A_BUF + 8'(4 * w), act);
            check(tag, act & mask, exp);
        end
    endtask

    initial begin
        logic [31:0] v, w0;
        int d, n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_DIV, v);  check("R1 div", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_POST, v); check("R1 post", v, 0);
        rd(A_FILL, v); check("R1 fill", v, 0);
        rd(A_BUF, v);  check("R1 buf0", v, 0);
        rd(A_BUF + 8'h1C, v); check("R1 buf7", v, 0);

        // R2: divider field shifted by one, bit 0 dropped
        wr(A_DIV, 32'hFFFF_FFFF);
        rd(A_DIV, v); check("R2 div all-ones", v, 32'h0000_FFFE);
        wr(A_DIV, 32'h0000_0007);
        rd(A_DIV, v); check("R2 div odd", v, 32'h0000_0006);

        // R9: post-processing register full width, then raw mode
        wr(A_POST, 32'hA5C3_0F01);
        rd(A_POST, v); check("R9 post rw", v, 32'hA5C3_0F01);
        wr(A_POST, 32'h0);
        rd(A_POST, v); check("R9 post zero", v, 0);

        // R3: enable bit readback
        wr(A_CTRL, 32'h8000_0000);
        rd(A_CTRL, v); check("R3 enable", v, 32'h8000_0000);

        // Vector table: divide value and requested bit count
        for (int i = 0; i < NVEC; i++) begin
            d = (VEC_DIV[i] == 0) ? 1 : VEC_DIV[i];
            n = (VEC_REQ[i] > 256) ? 256 : VEC_REQ[i];
            wr(A_DIV, 32'(VEC_DIV[i] << 1));
            start_fill(VEC_REQ[i]);
            rd(A_FILL, v); check("R4 R5 load", v, 32'(n));
            run_cycles(d * n);
            rd(A_FILL, v); check("R6 midway", v, 32'(exp_rem(n, d)));
            run_cycles(2 * d * n - 1 - (kk - 1));
            rd(A_FILL, v); check("R6 one left", v, 1);
            run_cycles(1);
            rd(A_FILL, v); check("R4 done", v, 0);
            check_words(n, d, "R7 R9 packing");
        end

        // R8: restart mid-fill from word 0 with new phase
        wr(A_DIV, 32'h2);
        start_fill(64);
        run_cycles(39);
        start_fill(32);
        rd(A_FILL, v); check("R8 reload", v, 32);
        run_cycles(63);
        rd(A_FILL, v); check("R8 one left", v, 1);
        run_cycles(1);
        rd(A_FILL, v); check("R8 done", v, 0);
        check_words(32, 1, "R8 word0 restart");

        // R3: disabled generator captures nothing
        rd(A_BUF, w0);
        wr(A_CTRL, 32'h0);
        start_fill(40);
        run_cycles(100);
        rd(A_FILL, v); check("R3 count held", v, 40);
        rd(A_BUF, v);  check("R3 buf held", v, w0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule